// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit watches the transmit and receive FIFOs of one SPI channel and turns their activity into a packed status word and a single interrupt line. It does not hold the FIFOs itself. The FIFOs supply their fill levels and their push and pop strobes, and the serial shifter supplies an idle indication. From these inputs the unit derives three kinds of information: ready conditions against programmable watermarks, sticky error flags for pushes into a full FIFO and pops from an empty one, and a transmit-complete indication.

A stale-data timer covers receive data that stays below the ready watermark. The timer counts cycles while the receive FIFO holds some data, is below its mark, and gets no new push. When the count reaches a 10-bit programmable limit, a trailing indication appears in the status word, and a sticky trailing flag is raised that can interrupt the host. Software clears the sticky flags by writing ones to a clear vector. The bit order of that vector is deliberately different from the order used in the status word.

Top module: `spiFifoStatus`

## Requirements
- R1: After reset, every sticky flag is clear, so status bits 5:2 read 0 and irq is low when all enables are zero.
- R2: Status bit 0 (transmit ready) is 1 exactly when txLevel <= txMark. Status bit 1 (receive ready) is 1 exactly when rxLevel >= rxMark. Both follow the inputs in the same cycle.
- R3: A push while the level equals FIFO_DEPTH sets the overrun flag on the next clock edge: status bit 3 for transmit, bit 5 for receive. A push below full leaves the flag unchanged.
- R4: A pop while the level is 0 sets the underrun flag on the next clock edge: status bit 2 for transmit, bit 4 for receive. A pop at a non-zero level leaves the flag unchanged.
- R5: A set error flag stays set, whatever happens on the FIFO ports, until it is cleared through the clear vector.
- R6: When clearWe is high, each 1 in clearBits clears one sticky flag on the next edge: bit0 trailing, bit1 receive overrun, bit2 receive underrun, bit3 transmit overrun, bit4 transmit underrun. A 0 bit leaves its flag alone. If a flag's set condition and its clear bit occur in the same cycle, the set wins.
- R7: The transmit level appears at status bits [6 +: LVL_W] and the receive level at bits [RX_OFF +: LVL_W], both unregistered.
- R8: Status bit RX_OFF+LVL_W+1 (transmit done) is 1 exactly when txLevel is 0 and shifterIdle is 1.
- R9: Status bit RX_OFF+LVL_W (trailing reached) becomes 1 once the receive FIFO has been stale for trailLimit consecutive clock edges. Stale means 0 < rxLevel < rxMark with no rxPush. The bit reads 0 in any cycle with rxPush or without stale data, and the count restarts from 0 afterwards.
- R10: The sticky trailing flag is set on the edge after the trailing indication is first seen. It persists after the data is no longer stale and is cleared only by clear bit 0.
- R11: irq is the OR over intEnable bit i AND source i, with the sources: 0 transmit ready, 1 receive ready, 2 transmit underrun, 3 transmit overrun, 4 receive underrun, 5 receive overrun, 6 sticky trailing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txPush | input | 1 | Write strobe into the transmit FIFO |
| txPop | input | 1 | Read strobe out of the transmit FIFO |
| txLevel | input | LVL_W | Transmit FIFO fill level |
| rxPush | input | 1 | Write strobe into the receive FIFO |
| rxPop | input | 1 | Read strobe out of the receive FIFO |
| rxLevel | input | LVL_W | Receive FIFO fill level |
| shifterIdle | input | 1 | Serial shifter has no word in flight |
| txMark | input | LVL_W | Transmit ready watermark |
| rxMark | input | LVL_W | Receive ready watermark |
| trailLimit | input | 10 | Stale-data cycle limit |
| intEnable | input | 7 | Per-source interrupt enables |
| clearWe | input | 1 | Qualifies clearBits |
| clearBits | input | 5 | Write-one-to-clear vector for sticky flags |
| statusWord | output | STATUS_W | Packed status word |
| irq | output | 1 | Combined interrupt |

## Verification
The bound checker checks three things on every cycle: overrun capture after a push at full, the persistence of a receive overrun until its clear bit is written, and the clear taking effect. It also checks that the trailing indication is absent whenever a receive push occurs, and that irq stays low with all enables off. The directed scenarios cover behaviour that a short property cannot show well. These are the exact cycle count at which the trailing timer fires for a given limit, the crossed mapping of each clear bit onto its status bit, set-over-clear priority, and the per-source masking of the interrupt.

// File: rtl/spiFifoStatusPkg.sv
package spiFifoStatusPkg;
  localparam int TRAIL_W = 10;
  localparam int ERR_N   = 4;
  localparam int SRC_N   = 7;
  localparam int CLR_N   = 5;

  // error index order: 0 txUnder, 1 txOver, 2 rxUnder, 3 rxOver (status bits 2..5)
  typedef struct packed {
    logic [ERR_N-1:0] errSet;
    logic [ERR_N-1:0] errClr;
    logic             trailClr;
    logic             stale;
  } statStrobes_t;
endpackage

// File: rtl/spiFifoStatusCtrl.sv
module spiFifoStatusCtrl
  import spiFifoStatusPkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int LVL_W      = 7
) (
  input  logic             txPush,
  input  logic             txPop,
  input  logic [LVL_W-1:0] txLevel,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] rxMark,
  input  logic             clearWe,
  input  logic [CLR_N-1:0] clearBits,
  output statStrobes_t     strb
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  logic txFull, txEmpty, rxFull, rxEmpty;

  always_comb begin
    txFull  = (txLevel == FULL_LVL);
    txEmpty = (txLevel == '0);
    rxFull  = (rxLevel == FULL_LVL);
    rxEmpty = (rxLevel == '0);

    strb.errSet[0] = txPop  && txEmpty;
    strb.errSet[1] = txPush && txFull;
    strb.errSet[2] = rxPop  && rxEmpty;
    strb.errSet[3] = rxPush && rxFull;

    // clear vector order differs from status order
    strb.errClr[0] = clearWe && clearBits[4];
    strb.errClr[1] = clearWe && clearBits[3];
    strb.errClr[2] = clearWe && clearBits[2];
    strb.errClr[3] = clearWe && clearBits[1];
    strb.trailClr  = clearWe && clearBits[0];

    strb.stale = !rxEmpty && (rxLevel < rxMark) && !rxPush;
  end
endmodule

// File: rtl/spiFifoStatusDp.sv
module spiFifoStatusDp
  import spiFifoStatusPkg::*;
#(
  parameter int LVL_W    = 7,
  parameter int RX_OFF   = 13,
  parameter int STATUS_W = RX_OFF + LVL_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  statStrobes_t        strb,
  input  logic [LVL_W-1:0]    txLevel,
  input  logic [LVL_W-1:0]    rxLevel,
  input  logic [LVL_W-1:0]    txMark,
  input  logic [LVL_W-1:0]    rxMark,
  input  logic                shifterIdle,
  input  logic [TRAIL_W-1:0]  trailLimit,
  input  logic [SRC_N-1:0]    intEnable,
  output logic [STATUS_W-1:0] statusWord,
  output logic                irq
);
  localparam int TZ_BIT   = RX_OFF + LVL_W;
  localparam int DONE_BIT = RX_OFF + LVL_W + 1;

  logic [ERR_N-1:0]   errFlags;
  logic [TRAIL_W-1:0] trailCnt;
  logic               trailReached;
  logic               trailSticky;
  logic               txReady, rxReady, txDone;
  logic [SRC_N-1:0]   srcVec;

  for (genvar i = 0; i < ERR_N; i++) begin : g_err
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 errFlags[i] <= 1'b0;
      else if (strb.errSet[i])   errFlags[i] <= 1'b1;
      else if (strb.errClr[i])   errFlags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     trailCnt <= '0;
    else if (!strb.stale)          trailCnt <= '0;
    else if (trailCnt < trailLimit) trailCnt <= trailCnt + 1'b1;
  end

  assign trailReached = strb.stale && (trailCnt >= trailLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              trailSticky <= 1'b0;
    else if (trailReached)  trailSticky <= 1'b1;
    else if (strb.trailClr) trailSticky <= 1'b0;
  end

  always_comb begin
    txReady = (txLevel <= txMark);
    rxReady = (rxLevel >= rxMark);
    txDone  = (txLevel == '0) && shifterIdle;

    statusWord                   = '0;
    statusWord[0]                = txReady;
    statusWord[1]                = rxReady;
    statusWord[5:2]              = errFlags;
    statusWord[6 +: LVL_W]       = txLevel;
    statusWord[RX_OFF +: LVL_W]  = rxLevel;
    statusWord[TZ_BIT]           = trailReached;
    statusWord[DONE_BIT]         = txDone;

    srcVec = {trailSticky, errFlags, rxReady, txReady};
    irq    = |(srcVec & intEnable);
  end
endmodule

// File: rtl/spiFifoStatus.sv
module spiFifoStatus
  import spiFifoStatusPkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1),
  parameter int RX_OFF     = 6 + LVL_W,
  parameter int STATUS_W   = RX_OFF + LVL_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txPush,
  input  logic                txPop,
  input  logic [LVL_W-1:0]    txLevel,
  input  logic                rxPush,
  input  logic                rxPop,
  input  logic [LVL_W-1:0]    rxLevel,
  input  logic                shifterIdle,
  input  logic [LVL_W-1:0]    txMark,
  input  logic [LVL_W-1:0]    rxMark,
  input  logic [9:0]          trailLimit,
  input  logic [6:0]          intEnable,
  input  logic                clearWe,
  input  logic [4:0]          clearBits,
  output logic [STATUS_W-1:0] statusWord,
  output logic                irq
);
  statStrobes_t strb;

  spiFifoStatusCtrl #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) ctrl_i (
    .txPush(txPush), .txPop(txPop), .txLevel(txLevel),
    .rxPush(rxPush), .rxPop(rxPop), .rxLevel(rxLevel),
    .rxMark(rxMark), .clearWe(clearWe), .clearBits(clearBits),
    .strb(strb)
  );

  spiFifoStatusDp #(.LVL_W(LVL_W), .RX_OFF(RX_OFF), .STATUS_W(STATUS_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txLevel(txLevel), .rxLevel(rxLevel), .txMark(txMark), .rxMark(rxMark),
    .shifterIdle(shifterIdle), .trailLimit(trailLimit), .intEnable(intEnable),
    .statusWord(statusWord), .irq(irq)
  );
endmodule

// File: rtl/spiFifoStatusChk.sv
module spiFifoStatusChk #(
  parameter int FIFO_DEPTH = 64,
  parameter int LVL_W      = 7,
  parameter int RX_OFF     = 13,
  parameter int STATUS_W   = RX_OFF + LVL_W + 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                txPush,
  input logic [LVL_W-1:0]    txLevel,
  input logic                rxPush,
  input logic [LVL_W-1:0]    rxLevel,
  input logic [6:0]          intEnable,
  input logic                clearWe,
  input logic [4:0]          clearBits,
  input logic [STATUS_W-1:0] statusWord,
  input logic                irq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);
  localparam int TZ_BIT = RX_OFF + LVL_W;

  p_tx_overrun_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txPush && txLevel == FULL_LVL) |=> statusWord[3]);

  p_rx_overrun_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[5] && !(clearWe && clearBits[1])) |=> statusWord[5]);

  p_rx_overrun_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clearWe && clearBits[1] && !(rxPush && rxLevel == FULL_LVL)) |=> !statusWord[5]);

  p_trail_push_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> !statusWord[TZ_BIT]);

  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable == '0) |-> !irq);
endmodule

bind spiFifoStatus spiFifoStatusChk #(
  .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .RX_OFF(RX_OFF), .STATUS_W(STATUS_W)
) chk_i (
  .clk(clk), .rstN(rstN), .txPush(txPush), .txLevel(txLevel),
  .rxPush(rxPush), .rxLevel(rxLevel), .intEnable(intEnable),
  .clearWe(clearWe), .clearBits(clearBits), .statusWord(statusWord), .irq(irq)
);

// File: tb/spiFifoStatus_tb_top.sv
`timescale 1ns/1ps
module spiFifoStatus_tb_top;
  localparam int DEPTH = 64;
  localparam int LW    = 7;
  localparam int ROFF  = 13;
  localparam int SW    = ROFF + LW + 2;
  localparam int TZ    = ROFF + LW;
  localparam int DN    = ROFF + LW + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txPush = 0, txPop = 0, rxPush = 0, rxPop = 0;
  logic [LW-1:0] txLevel = '0, rxLevel = '0, txMark = 7'd4, rxMark = 7'd8;
  logic shifterIdle = 1'b1;
  logic [9:0] trailLimit = 10'd5;
  logic [6:0] intEnable = '0;
  logic clearWe = 0;
  logic [4:0] clearBits = '0;
  logic [SW-1:0] statusWord;
  logic irq;

  int testsRun = 0;
  int testsFail = 0;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  spiFifoStatus #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .txPush(txPush), .txPop(txPop), .txLevel(txLevel),
    .rxPush(rxPush), .rxPop(rxPop), .rxLevel(rxLevel), .shifterIdle(shifterIdle),
    .txMark(txMark), .rxMark(rxMark), .trailLimit(trailLimit),
    .intEnable(intEnable), .clearWe(clearWe), .clearBits(clearBits),
    .statusWord(statusWord), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearSticky(input logic [4:0] bits);
    clearWe = 1; clearBits = bits; tick(1); clearWe = 0; clearBits = '0;
  endtask

  task automatic testReset();
    check("R1 errors", 32'(statusWord[5:2]), 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic testReadyLevels();
    txLevel = 7'd5; rxLevel = 7'd8; #1;
    check("R2 tx not ready", 32'(statusWord[0]), 0);
    check("R2 rx ready", 32'(statusWord[1]), 1);
    check("R7 tx level", 32'(statusWord[6 +: LW]), 5);
    check("R7 rx level", 32'(statusWord[ROFF +: LW]), 8);
    txLevel = 7'd4; rxLevel = 7'd7; #1;
    check("R2 tx ready", 32'(statusWord[0]), 1);
    check("R2 rx not ready", 32'(statusWord[1]), 0);
    tick(1);
  endtask

  task automatic testOverrun();
    txLevel = 7'd63; txPush = 1; tick(1); txPush = 0;
    check("R3 tx push below full", 32'(statusWord[3]), 0);
    txLevel = 7'd64; txPush = 1; #1;
    check("R3 tx before edge", 32'(statusWord[3]), 0);
    tick(1); txPush = 0;
    check("R3 tx overrun", 32'(statusWord[3]), 1);
    rxLevel = 7'd64; rxPush = 1; tick(1); rxPush = 0;
    check("R3 rx overrun", 32'(statusWord[5]), 1);
    txLevel = 7'd10; rxLevel = 7'd0;
  endtask

  task automatic testUnderrun();
    txLevel = 7'd1; txPop = 1; tick(1); txPop = 0;
    check("R4 tx pop nonempty", 32'(statusWord[2]), 0);
    txLevel = 7'd0; txPop = 1; tick(1); txPop = 0;
    check("R4 tx underrun", 32'(statusWord[2]), 1);
    rxPop = 1; tick(1); rxPop = 0;
    check("R4 rx underrun", 32'(statusWord[4]), 1);
    txLevel = 7'd3; txPush = 1; rxLevel = 7'd9; rxPush = 1; tick(1);
    txPush = 0; rxPush = 0; rxLevel = 7'd0; tick(4);
    check("R5 sticky hold", 32'(statusWord[5:2]), 32'hF);
  endtask

  task automatic testClear();
    clearSticky(5'b01000);
    check("R6 bit3 clears tx overrun", 32'(statusWord[5:2]), 32'hD);
    clearSticky(5'b00010);
    check("R6 bit1 clears rx overrun", 32'(statusWord[5:2]), 32'h5);
    clearSticky(5'b10000);
    check("R6 bit4 clears tx underrun", 32'(statusWord[5:2]), 32'h4);
    clearSticky(5'b00100);
    check("R6 bit2 clears rx underrun", 32'(statusWord[5:2]), 32'h0);
    txLevel = 7'd64; txPush = 1; clearWe = 1; clearBits = 5'b01000; tick(1);
    txPush = 0; clearWe = 0; clearBits = '0;
    check("R6 set wins", 32'(statusWord[3]), 1);
    clearSticky(5'h1f);
    check("R6 clear all", 32'(statusWord[5:2]), 0);
    txLevel = 7'd0;
  endtask

  task automatic testTxDone();
    shifterIdle = 0; #1;
    check("R8 busy shifter", 32'(statusWord[DN]), 0);
    shifterIdle = 1; #1;
    check("R8 done", 32'(statusWord[DN]), 1);
    txLevel = 7'd3; #1;
    check("R8 data left", 32'(statusWord[DN]), 0);
    tick(1);
  endtask

  task automatic testTrailing();
    intEnable = 7'h40; rxLevel = 7'd0; tick(1);
    rxLevel = 7'd2;
    tick(4);
    check("R9 before limit", 32'(statusWord[TZ]), 0);
    tick(1);
    check("R9 at limit", 32'(statusWord[TZ]), 1);
    check("R10 sticky not yet", 32'(irq), 0);
    tick(1);
    check("R10 sticky irq", 32'(irq), 1);
    rxPush = 1; #1;
    check("R9 push hides", 32'(statusWord[TZ]), 0);
    tick(1); rxPush = 0;
    tick(1);
    check("R9 restarted", 32'(statusWord[TZ]), 0);
    check("R10 sticky persists", 32'(irq), 1);
    clearSticky(5'b00001);
    check("R10 cleared", 32'(irq), 0);
    rxLevel = 7'd0; intEnable = '0; tick(1);
  endtask

  task automatic testIrq();
    txLevel = 7'd0; rxLevel = 7'd0; intEnable = 7'h01; #1;
    check("R11 tx ready src", 32'(irq), 1);
    intEnable = 7'h02; #1;
    check("R11 rx ready masked", 32'(irq), 0);
    txLevel = 7'd64; txPush = 1; tick(1); txPush = 0; txLevel = 7'd10;
    intEnable = 7'h77; #1;
    check("R11 overrun not enabled", 32'(irq), 0);
    intEnable = 7'h08; #1;
    check("R11 tx overrun src", 32'(irq), 1);
    clearSticky(5'h1f);
    check("R11 after clear", 32'(irq), 0);
    intEnable = '0;
  endtask

  initial begin
    tick(2);
    testReset();
    rstN = 1;
    tick(1);
    testReset();
    testReadyLevels();
    testOverrun();
    testUnderrun();
    testClear();
    testTxDone();
    testTrailing();
    testIrq();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1;
      testsRun++; testsFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end
endmodule